// File: doc/BRIEF.md
# NAND Flash Reset and Identification Reader

This block is a host-side sequencer that runs a NAND flash device through its start-up probe. A one-cycle `start` pulse makes it reset the device, wait for ready/busy to come back, issue the identification command with its single dummy address, and read the identification bytes into an output register. The block then flags whether the first byte carries the expected maker code.

The block drives every strobe on the flash bus: chip enable, command latch, address latch, write enable and read enable. It also owns one side of the bidirectional data bus. Every interval on the bus is a parameter counted in clock cycles. These are the write pulse low and high widths, the settle time before ready/busy is trusted, the read strobe low and high widths, and the two turnaround gaps before the first read strobe. A timeout limit on the busy wait stops a device that never becomes ready from hanging the sequence.

Top module: `nand_id_probe`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge) the bus is idle: `ce_n`=1, `cle`=0, `ale`=0, `we_n`=1, `re_n`=1. `done`, `busy`, `id_match` and `timeout_err` are 0 and `id_bytes` is all zero.
- R2: In the cycle after `start` is sampled high, the reset byte FFh goes out as a command. `ce_n`=0 and `cle`=1 for the whole write, with `we_n` low for T_WP cycles and then high for T_WH cycles, and the byte is held on `dq` throughout.
- R3: After the reset write, `ce_n` stays low with all other strobes inactive for T_WB cycles. The block then waits until `rb_n` is sampled high, and only then starts the next command. If `rb_n` is already high when it is first examined, the wait lasts one cycle.
- R4: If `rb_n` is still low after TIMEOUT cycles of waiting (a high sample in the last cycle still counts as ready), the block skips the identification phase. It goes straight to done with `timeout_err`=1, `id_match`=0 and `id_bytes` zero, and releases the bus (`ce_n`=1).
- R5: The identification command 90h is written with `cle`=1, followed by exactly one address write of 00h with `ale`=1. Each write has the same T_WP low and T_WH high shape as in R2. `dq` is driven only during command and address writes and is released at all other times.
- R6: After the address write, all strobes stay inactive with `ce_n`=0 for max(T_AR, T_WHR-T_WH, 1) cycles. This places the first `re_n` fall at least T_WHR cycles after the last `we_n` rise and at least T_AR cycles after `ale` falls.
- R7: Exactly ID_BYTES (five) read strobes follow, each T_REA cycles low and T_REH cycles high. Each byte is sampled from `dq` at the clock edge that ends its low phase. Byte k (k=0 first) is stored in `id_bytes[8k+7:8k]`.
- R8: At done, `id_match` is 1 exactly when the first byte read equals ECh and no timeout occurred.
- R9: `done` stays high with the bus idle until the next `start`. A `start` pulse while a sequence is running has no effect. A `start` at done begins a new sequence and clears `id_bytes`, `timeout_err` and `id_match`.
- R10: `busy` is 1 from the cycle after `start` is accepted until the cycle in which `done` rises, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run reset and identification |
| rb_n | input | 1 | Device ready (1) / busy (0) |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write enable, active low |
| re_n | output | 1 | Read enable, active low |
| dq | inout | 8 | Bidirectional data bus |
| id_bytes | output | 8*ID_BYTES | Captured identification bytes, byte 0 in the low bits |
| done | output | 1 | Sequence finished (held until next start) |
| busy | output | 1 | Sequence in progress |
| id_match | output | 1 | First byte equals the maker code |
| timeout_err | output | 1 | Busy wait exceeded TIMEOUT |

## Verification
The assertions guard the local, every-cycle properties:
- `cle` and `ale` are never high together, and `dq` is driven only inside a write with chip enable low.
- The first command after reset always follows a high `rb_n` sample.
- The two turnaround gaps hold at each `re_n` fall.
- No run issues more read strobes than bytes.
- A match flag only appears with ECh in byte 0.

Whole-run behaviour needs the bench's model, which predicts the complete strobe waveform cycle by cycle and emulates the device's busy time and byte output. Only that model can show:
- the exact busy-wait length, including the two timeout boundaries one cycle apart;
- the byte order in `id_bytes`;
- that a mid-run `start` changes nothing;
- that a restart after a timeout clears the flags.

// File: rtl/nand_id_pkg.sv
// Package: shared encodings for the NAND reset/identification reader.
// Holds the sequencer state type, the fixed bus byte values and a small
// helper used to derive counter widths from the timing parameters.
package nand_id_pkg;

    // Sequencer phases, one per bus phase of the probe.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_WL,
        ST_RST_WH,
        ST_SETTLE,
        ST_BUSY,
        ST_ID_WL,
        ST_ID_WH,
        ST_AD_WL,
        ST_AD_WH,
        ST_GAP,
        ST_RD_L,
        ST_RD_H,
        ST_DONE
    } seq_state_e;

    localparam logic [7:0] CMD_RESET   = 8'hFF;
    localparam logic [7:0] CMD_READ_ID = 8'h90;
    localparam logic [7:0] ADDR_ID     = 8'h00;
    localparam logic [7:0] MAKER_CODE  = 8'hEC;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nand_phase_timer.sv
// Module: phase timer for the sequencer.
// Loads a phase length when a new phase starts and counts down to zero;
// 'expired' is high in the last cycle of the phase. Assumes len >= 1.
module nand_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count the current phase down to zero, reloading on phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

    // R2
    phase_len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0));

endmodule

// File: rtl/nand_id_capture.sv
// Module: identification byte store.
// One byte register per identification byte; the sequencer names which
// byte to load and when. Cleared when a new run is accepted.
// Assumes cap_idx < ID_BYTES whenever cap_en is high.
module nand_id_capture
    import nand_id_pkg::*;
#(
    parameter int ID_BYTES = 5,
    parameter int IDX_W    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  cap_en,
    input  logic [IDX_W-1:0]      cap_idx,
    input  logic [7:0]            din,
    output logic [8*ID_BYTES-1:0] id_bytes,
    output logic                  maker_ok
);

    for (genvar k = 0; k < ID_BYTES; k++) begin : g_byte
        logic [7:0] byte_q;

        // Hold byte k; load it when the sequencer samples slot k.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                byte_q <= '0;
            end else if (cap_en && (cap_idx == IDX_W'(k))) begin
                byte_q <= din;
            end
        end

        assign id_bytes[8*k +: 8] = byte_q;
    end

    assign maker_ok = (id_bytes[7:0] == MAKER_CODE);

    // R7
    cap_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (int'(cap_idx) < ID_BYTES));

endmodule

// File: rtl/nand_id_seq.sv
// Module: bus sequencer for reset + identification read.
// Walks the phases reset-write, settle, busy-wait, command-write,
// address-write, turnaround gap and ID_BYTES read strobes, then done.
// Strobes decode from the registered state, so they never glitch
// between edges. Assumes all timing parameters are >= 1 cycle.
module nand_id_seq
    import nand_id_pkg::*;
#(
    parameter int T_WP     = 2,
    parameter int T_WH     = 2,
    parameter int T_WB     = 3,
    parameter int T_WHR    = 6,
    parameter int T_AR     = 3,
    parameter int T_REA    = 3,
    parameter int T_REH    = 2,
    parameter int TIMEOUT  = 64,
    parameter int ID_BYTES = 5,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rb_n,
    output logic             ce_n,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [7:0]       dq_out,
    output logic             dq_oe,
    output logic             cap_en,
    output logic [IDX_W-1:0] cap_idx,
    output logic             clear,
    output logic             done,
    output logic             busy,
    output logic             timeout_err
);

    localparam int GAP_LEN = max_of(max_of(T_AR, T_WHR - T_WH), 1);
    localparam int MAX_LEN = max_of(max_of(max_of(T_WP, T_WH), max_of(T_WB, T_REA)),
                                    max_of(max_of(T_REH, TIMEOUT), max_of(GAP_LEN, T_WHR)));
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    localparam logic [CNT_W-1:0] L_WP   = CNT_W'(T_WP);
    localparam logic [CNT_W-1:0] L_WH   = CNT_W'(T_WH);
    localparam logic [CNT_W-1:0] L_WB   = CNT_W'(T_WB);
    localparam logic [CNT_W-1:0] L_TO   = CNT_W'(TIMEOUT);
    localparam logic [CNT_W-1:0] L_GAP  = CNT_W'(GAP_LEN);
    localparam logic [CNT_W-1:0] L_REA  = CNT_W'(T_REA);
    localparam logic [CNT_W-1:0] L_REH  = CNT_W'(T_REH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_BYTES - 1);

    seq_state_e       state_q, state_n;
    logic             accept;
    logic             load;
    logic [CNT_W-1:0] len;
    logic             expired;
    logic [IDX_W-1:0] rd_idx_q;
    logic             err_q;

    assign accept = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign clear  = accept;

    // Phase timer shared by all timed phases.
    nand_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .len     (len),
        .expired (expired)
    );

    // Next-phase selection.
    always_comb begin
        state_n = state_q;
        case (state_q)
            ST_IDLE:   if (start) state_n = ST_RST_WL;
            ST_DONE:   if (start) state_n = ST_RST_WL;
            ST_RST_WL: if (expired) state_n = ST_RST_WH;
            ST_RST_WH: if (expired) state_n = ST_SETTLE;
            ST_SETTLE: if (expired) state_n = ST_BUSY;
            ST_BUSY: begin
                if (rb_n)         state_n = ST_ID_WL;
                else if (expired) state_n = ST_DONE;
            end
            ST_ID_WL:  if (expired) state_n = ST_ID_WH;
            ST_ID_WH:  if (expired) state_n = ST_AD_WL;
            ST_AD_WL:  if (expired) state_n = ST_AD_WH;
            ST_AD_WH:  if (expired) state_n = ST_GAP;
            ST_GAP:    if (expired) state_n = ST_RD_L;
            ST_RD_L:   if (expired) state_n = ST_RD_H;
            ST_RD_H: begin
                if (expired) state_n = (rd_idx_q == LAST_IDX) ? ST_DONE : ST_RD_L;
            end
            default:   state_n = ST_IDLE;
        endcase
    end

    // Timer load on every phase change, with the entered phase's length.
    always_comb begin
        load = (state_n != state_q);
        case (state_n)
            ST_RST_WL, ST_ID_WL, ST_AD_WL: len = L_WP;
            ST_RST_WH, ST_ID_WH, ST_AD_WH: len = L_WH;
            ST_SETTLE:                     len = L_WB;
            ST_BUSY:                       len = L_TO;
            ST_GAP:                        len = L_GAP;
            ST_RD_L:                       len = L_REA;
            ST_RD_H:                       len = L_REH;
            default:                       len = CNT_W'(1);
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Read-strobe index: which identification byte the current strobe fetches.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            rd_idx_q <= '0;
        end else if ((state_q == ST_RD_H) && expired) begin
            rd_idx_q <= rd_idx_q + IDX_W'(1);
        end
    end

    // Timeout flag: set when the busy wait runs out, cleared on a new run.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            err_q <= 1'b0;
        end else if ((state_q == ST_BUSY) && !rb_n && expired) begin
            err_q <= 1'b1;
        end
    end

    // Bus strobe and data-drive decode per phase.
    always_comb begin
        ce_n   = 1'b0;
        cle    = 1'b0;
        ale    = 1'b0;
        we_n   = 1'b1;
        re_n   = 1'b1;
        dq_out = 8'h00;
        dq_oe  = 1'b0;
        case (state_q)
            ST_IDLE, ST_DONE: ce_n = 1'b1;
            ST_RST_WL, ST_RST_WH: begin
                cle    = 1'b1;
                we_n   = (state_q == ST_RST_WH);
                dq_out = CMD_RESET;
                dq_oe  = 1'b1;
            end
            ST_ID_WL, ST_ID_WH: begin
                cle    = 1'b1;
                we_n   = (state_q == ST_ID_WH);
                dq_out = CMD_READ_ID;
                dq_oe  = 1'b1;
            end
            ST_AD_WL, ST_AD_WH: begin
                ale    = 1'b1;
                we_n   = (state_q == ST_AD_WH);
                dq_out = ADDR_ID;
                dq_oe  = 1'b1;
            end
            ST_RD_L: re_n = 1'b0;
            default: ;
        endcase
    end

    assign cap_en      = (state_q == ST_RD_L) && expired;
    assign cap_idx     = rd_idx_q;
    assign done        = (state_q == ST_DONE);
    assign busy        = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign timeout_err = err_q;

    // ---- checker state for the turnaround and strobe-count properties ----
    logic [CNT_W-1:0] since_we_q;
    logic [CNT_W-1:0] since_ale_q;
    logic [IDX_W:0]   re_falls_q;
    logic             re_n_q;

    // Cycles elapsed with we_n high / ale low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_we_q  <= '0;
            since_ale_q <= '0;
        end else begin
            if (!we_n)                  since_we_q <= '0;
            else if (~since_we_q != '0) since_we_q <= since_we_q + CNT_W'(1);
            if (ale)                     since_ale_q <= '0;
            else if (~since_ale_q != '0) since_ale_q <= since_ale_q + CNT_W'(1);
        end
    end

    // Count read-enable falls within one run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            re_n_q     <= 1'b1;
            re_falls_q <= '0;
        end else begin
            re_n_q <= re_n;
            if (accept)               re_falls_q <= '0;
            else if (re_n_q && !re_n) re_falls_q <= re_falls_q + (IDX_W+1)'(1);
        end
    end

    // R3
    ready_before_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ID_WL) && ($past(state_q) == ST_BUSY)) |-> $past(rb_n));

    // R6
    whr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(re_n) |-> (since_we_q >= CNT_W'(T_WHR)));

    // R6
    ar_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(re_n) |-> (since_ale_q >= CNT_W'(T_AR)));

    // R4
    timeout_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_BUSY) && !rb_n && expired) |=> (done && timeout_err));

    // R7
    read_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(re_falls_q) <= ID_BYTES);

endmodule

// File: rtl/nand_id_probe.sv
// Module: NAND flash reset and identification reader (top).
// Joins the bus sequencer and the byte store, and owns the tristate on
// the data bus. Assumes rb_n is already synchronous to clk.
module nand_id_probe
    import nand_id_pkg::*;
#(
    parameter int T_WP     = 2,
    parameter int T_WH     = 2,
    parameter int T_WB     = 3,
    parameter int T_WHR    = 6,
    parameter int T_AR     = 3,
    parameter int T_REA    = 3,
    parameter int T_REH    = 2,
    parameter int TIMEOUT  = 64,
    parameter int ID_BYTES = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  rb_n,
    output logic                  ce_n,
    output logic                  cle,
    output logic                  ale,
    output logic                  we_n,
    output logic                  re_n,
    inout  wire  [7:0]            dq,
    output logic [8*ID_BYTES-1:0] id_bytes,
    output logic                  done,
    output logic                  busy,
    output logic                  id_match,
    output logic                  timeout_err
);

    localparam int IDX_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

    logic [7:0]       dq_out;
    logic             dq_oe;
    logic [7:0]       dq_in;
    logic             cap_en;
    logic [IDX_W-1:0] cap_idx;
    logic             clear;
    logic             maker_ok;

    // Drive the bus only for write cycles; otherwise leave it to the device.
    assign dq    = dq_oe ? dq_out : 8'hzz;
    assign dq_in = dq;

    nand_id_seq #(
        .T_WP     (T_WP),
        .T_WH     (T_WH),
        .T_WB     (T_WB),
        .T_WHR    (T_WHR),
        .T_AR     (T_AR),
        .T_REA    (T_REA),
        .T_REH    (T_REH),
        .TIMEOUT  (TIMEOUT),
        .ID_BYTES (ID_BYTES),
        .IDX_W    (IDX_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rb_n        (rb_n),
        .ce_n        (ce_n),
        .cle         (cle),
        .ale         (ale),
        .we_n        (we_n),
        .re_n        (re_n),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe),
        .cap_en      (cap_en),
        .cap_idx     (cap_idx),
        .clear       (clear),
        .done        (done),
        .busy        (busy),
        .timeout_err (timeout_err)
    );

    nand_id_capture #(
        .ID_BYTES (ID_BYTES),
        .IDX_W    (IDX_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .din      (dq_in),
        .id_bytes (id_bytes),
        .maker_ok (maker_ok)
    );

    assign id_match = done && maker_ok && !timeout_err;

    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R5
    dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!ce_n && re_n && (cle || ale)));

    // R8
    match_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_match |-> (done && (id_bytes[7:0] == MAKER_CODE)));

    // R9
    done_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ce_n && !busy));

endmodule

// File: tb/nand_id_probe_tb.sv
`timescale 1ns/1ps
module nand_id_probe_tb;

    localparam int T_WP = 2, T_WH = 2, T_WB = 3, T_WHR = 6, T_AR = 3;
    localparam int T_REA = 3, T_REH = 2, TIMEOUT = 60, NB = 5;
    localparam int GAP = (T_AR > T_WHR - T_WH) ? ((T_AR > 1) ? T_AR : 1)
                                              : ((T_WHR - T_WH > 1) ? T_WHR - T_WH : 1);

    // pin code {ce_n, cle, ale, we_n, re_n}
    localparam logic [4:0] P_IDLE  = 5'b10011;
    localparam logic [4:0] P_CMD_L = 5'b01001;
    localparam logic [4:0] P_CMD_H = 5'b01011;
    localparam logic [4:0] P_ADR_L = 5'b00101;
    localparam logic [4:0] P_ADR_H = 5'b00111;
    localparam logic [4:0] P_WAIT  = 5'b00011;
    localparam logic [4:0] P_RD_L  = 5'b00010;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, start, rb_n;
    wire  ce_n, cle, ale, we_n, re_n;
    wire  [7:0] dq;
    wire  [8*NB-1:0] id_bytes;
    wire  done, busy, id_match, timeout_err;

    nand_id_probe #(
        .T_WP(T_WP), .T_WH(T_WH), .T_WB(T_WB), .T_WHR(T_WHR), .T_AR(T_AR),
        .T_REA(T_REA), .T_REH(T_REH), .TIMEOUT(TIMEOUT), .ID_BYTES(NB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rb_n(rb_n),
        .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
        .dq(dq), .id_bytes(id_bytes), .done(done), .busy(busy),
        .id_match(id_match), .timeout_err(timeout_err)
    );

    // ---- behavioural device model ----
    logic [7:0] rom [NB];
    int   busy_left, bl_cfg, ptr;
    bit   id_cmd, id_mode;
    logic prev_we, prev_re;
    logic [7:0] rd_byte;
    assign rd_byte = (ptr < NB) ? rom[ptr] : 8'h00;
    assign dq = (id_mode && !re_n && !ce_n) ? rd_byte : 8'hzz;

    // ---- expected bus trace ----
    logic [4:0] q_pins[$];
    logic [7:0] q_dq[$];
    string      q_tag[$];

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int n, input logic [4:0] p, input logic [7:0] d, input string t);
        for (int i = 0; i < n; i++) begin
            q_pins.push_back(p);
            q_dq.push_back(d);
            q_tag.push_back(t);
        end
    endtask

    // One cycle: compare pins with the trace, then advance the device model.
    task automatic step();
        logic [4:0] pins, ep;
        logic [7:0] ed;
        string tg;
        @(negedge clk);
        pins = {ce_n, cle, ale, we_n, re_n};
        if (q_pins.size() > 0) begin
            ep = q_pins.pop_front();
            ed = q_dq.pop_front();
            tg = q_tag.pop_front();
        end else begin
            ep = P_IDLE; ed = 8'h00; tg = "R9";
        end
        chk(pins == ep, tg, "bus strobes", 64'(pins), 64'(ep));
        if (!we_n) chk(dq == ed, tg, "write byte on dq", 64'(dq), 64'(ed));
        if (busy_left > 0) begin
            busy_left--;
            if (busy_left == 0) rb_n = 1'b1;
        end
        if (we_n && !prev_we && !ce_n) begin
            if (cle && dq == 8'hFF) begin
                busy_left = bl_cfg; rb_n = 1'b0; id_mode = 0; id_cmd = 0;
            end else if (cle && dq == 8'h90) begin
                id_cmd = 1; id_mode = 0;
            end else if (ale && id_cmd && dq == 8'h00) begin
                id_mode = 1; id_cmd = 0; ptr = 0;
            end
        end
        if (id_mode && re_n && !prev_re) ptr++;
        prev_we = we_n;
        prev_re = re_n;
    endtask

    // One probe run: device busy for bl cycles, optional stray start at cycle glitch.
    task automatic run(input int bl, input int glitch);
        int s, x, blen, idx;
        bit to;
        logic [8*NB-1:0] exp_bytes;
        while (!rb_n) step();
        bl_cfg = bl;
        s = T_WP + T_WH + T_WB;
        x = (s + 1 > T_WP + bl + 1) ? s + 1 : T_WP + bl + 1;
        to = (x > s + TIMEOUT);
        blen = to ? TIMEOUT : x - s;
        push(T_WP, P_CMD_L, 8'hFF, "R2");
        push(T_WH, P_CMD_H, 8'hFF, "R2");
        push(T_WB + blen, P_WAIT, 8'h00, to ? "R4" : "R3");
        if (!to) begin
            push(T_WP, P_CMD_L, 8'h90, "R5");
            push(T_WH, P_CMD_H, 8'h90, "R5");
            push(T_WP, P_ADR_L, 8'h00, "R5");
            push(T_WH, P_ADR_H, 8'h00, "R5");
            push(GAP, P_WAIT, 8'h00, "R6");
            for (int k = 0; k < NB; k++) begin
                push(T_REA, P_RD_L, 8'h00, "R7");
                push(T_REH, P_WAIT, 8'h00, "R7");
            end
        end
        exp_bytes = '0;
        if (!to) for (int k = 0; k < NB; k++) exp_bytes[8*k +: 8] = rom[k];
        start = 1'b1;
        step();
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R10", "busy after start", 64'({busy, done}), 64'(2'b10));
        idx = 1;
        while (q_pins.size() > 0) begin
            if (idx == glitch) start = 1'b1;
            step();
            start = 1'b0;
            idx++;
        end
        step();
        chk(done == 1'b1, "R9", "done at end", 64'(done), 64'(1));
        chk(busy == 1'b0, "R10", "busy at end", 64'(busy), 64'(0));
        chk(timeout_err == to, "R4", "timeout flag", 64'(timeout_err), 64'(to));
        chk(id_match == (!to && rom[0] == 8'hEC), "R8", "maker match",
            64'(id_match), 64'(!to && rom[0] == 8'hEC));
        chk(id_bytes == exp_bytes, "R7", "captured bytes", 64'(id_bytes), 64'(exp_bytes));
        repeat (4) step();
        chk(done == 1'b1, "R9", "done held", 64'(done), 64'(1));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL R9 watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; rb_n = 1'b1;
        busy_left = 0; bl_cfg = 1; ptr = 0; id_cmd = 0; id_mode = 0;
        prev_we = 1'b1; prev_re = 1'b1;
        for (int k = 0; k < NB; k++) rom[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({ce_n, cle, ale, we_n, re_n} == P_IDLE, "R1", "idle strobes",
            64'({ce_n, cle, ale, we_n, re_n}), 64'(P_IDLE));
        chk({done, busy, id_match, timeout_err} == 4'b0000, "R1", "flags",
            64'({done, busy, id_match, timeout_err}), 64'(0));
        chk(id_bytes == '0, "R1", "id bytes", 64'(id_bytes), 64'(0));

        // normal device, real busy period
        rom[0] = 8'hEC; rom[1] = 8'hDA; rom[2] = 8'h10; rom[3] = 8'h95; rom[4] = 8'h44;
        run(12, -1);
        // wrong maker, ready before the wait, stray start mid-run (R9)
        rom[0] = 8'hAD; rom[1] = 8'h5A; rom[2] = 8'h01; rom[3] = 8'h22; rom[4] = 8'h3C;
        run(1, 20);
        // R4 boundary: ready seen on the last wait cycle
        rom[0] = 8'hEC; rom[1] = 8'hF1; rom[2] = 8'h00; rom[3] = 8'h95; rom[4] = 8'h40;
        run(64, -1);
        // R4 boundary: one cycle later is a timeout
        run(65, -1);
        // R9: restart after timeout clears the flags
        rom[0] = 8'hEC; rom[1] = 8'hAA; rom[2] = 8'h90; rom[3] = 8'h15; rom[4] = 8'h54;
        run(30, 35);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule